// File: doc/BRIEF.md
# Converter Power-Down and Initialization Sequencer

This block governs the power-down and restart of the two paths of an audio converter, the capture (ADC) path and the playback (DAC) path. Each path has its own active-low power-down pin. While a pin is low, its path sits in power-down and the block holds that path's digital filter in reset. The two pins act independently of each other.

When the ADC pin is released, the capture path does not produce data at once. It first passes through an initialization window that lasts 2081 rising edges of the frame clock. For the whole of that window, and during power-down, the serial data word handed on to the output shifter is forced to all zeros. Once the count completes, the path reports valid data and passes the filter's sample through. The playback path has no such window: it runs as soon as its pin is released, and the capture sequence never touches it.

The pins and the frame clock come from outside the block's clock domain. Each is passed through a two-flop synchronizer before use.

Top module: `conv_pwr_seq`

## Requirements
- R1: While `rst_n` is low, both state outputs read 0 (power-down), both filter resets are high, `adc_valid` is low and `adc_data_out` is zero. State encoding: 0 = power-down, 1 = init, 2 = run.
- R2: The level on `adc_pd_n` sampled at clock edge k selects the ADC transition made at edge k+2. A low level puts the ADC path in power-down (state 0), from any state. `adc_filt_rst` is high exactly while the ADC state is 0.
- R3: The level on `dac_pd_n` sampled at edge k sets the DAC state at edge k+2: 0 when low, 2 when high. The DAC state is never 1. `dac_filt_rst` is high exactly while the DAC state is 0.
- R4: When the ADC path is in power-down and its synchronized pin is high, it moves to init (state 1) with the count at zero. In init it counts frame-clock rising edges. On the 2081st counted edge it moves to run (state 2), and `adc_valid` is high exactly while the state is 2.
- R5: `adc_data_out` is all zeros while the ADC state is 0 or 1. It equals `adc_data_in` in the same cycle while the state is 2.
- R6: No activity on `dac_pd_n` changes the ADC state, the ADC count or `adc_valid`. No activity on `adc_pd_n` changes the DAC state.
- R7: Pulling `adc_pd_n` low during init, even for a single clock, discards the partial count. The next release starts a full 2081-edge window from zero.
- R8: A frame-clock rising edge is counted at edge k when `frame_clk` was sampled low at edge k-3 and high at edge k-2. Only edges seen while the state is 1 are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_pd_n | input | 1 | ADC power-down, active low, asynchronous |
| dac_pd_n | input | 1 | DAC power-down, active low, asynchronous |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous |
| adc_data_in | input | 16 | Sample from the decimation filter |
| adc_data_out | output | 16 | Sample to the serial shifter, zero unless running |
| adc_filt_rst | output | 1 | Holds the ADC filter in reset |
| dac_filt_rst | output | 1 | Holds the DAC filter in reset |
| adc_state | output | 2 | ADC path state (0 = power-down, 1 = init, 2 = run) |
| dac_state | output | 2 | DAC path state (0 = power-down, 2 = run) |
| adc_valid | output | 1 | ADC data valid |

## Verification
Two events can land in the same clock: a frame-clock rising edge that would advance the count, and an ADC pin drop that forces power-down. Power-down must win, and the count must restart from zero. The bench provokes this with a one-clock low pulse timed against the frame clock during init. It also toggles the DAC pin in the middle of an ADC window. A behavioural model, fed the same delayed pin and frame samples, predicts every output, and each output is compared against it on every clock.

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq #(
  parameter int INIT_FRAMES = 2081,
  parameter int DATA_W      = 16,
  localparam int CNT_W      = $clog2(INIT_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_pd_n,
  input  logic              dac_pd_n,
  input  logic              frame_clk,
  input  logic [DATA_W-1:0] adc_data_in,
  output logic [DATA_W-1:0] adc_data_out,
  output logic              adc_filt_rst,
  output logic              dac_filt_rst,
  output logic [1:0]        adc_state,
  output logic [1:0]        dac_state,
  output logic              adc_valid
);

  localparam logic [1:0] ST_PD   = 2'd0;
  localparam logic [1:0] ST_INIT = 2'd1;
  localparam logic [1:0] ST_RUN  = 2'd2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);

  logic [1:0] a_sync, d_sync;
  logic [2:0] f_sync;
  logic [1:0] a_st, d_st;
  logic [CNT_W-1:0] cnt;

  wire a_on    = a_sync[1];
  wire d_on    = d_sync[1];
  wire fr_rise = f_sync[1] & ~f_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      d_sync <= '0;
      f_sync <= '0;
    end else begin
      a_sync <= {a_sync[0], adc_pd_n};
      d_sync <= {d_sync[0], dac_pd_n};
      f_sync <= {f_sync[1:0], frame_clk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_st <= ST_PD;
      cnt  <= '0;
    end else if (!a_on) begin
      a_st <= ST_PD;
      cnt  <= '0;
    end else begin
      case (a_st)
        ST_PD: begin
          a_st <= ST_INIT;
          cnt  <= '0;
        end
        ST_INIT: if (fr_rise) begin
          if (cnt == LAST) begin
            a_st <= ST_RUN;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: a_st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_st <= ST_PD;
    else        d_st <= d_on ? ST_RUN : ST_PD;
  end

  assign adc_state    = a_st;
  assign dac_state    = d_st;
  assign adc_valid    = (a_st == ST_RUN);
  assign adc_filt_rst = (a_st == ST_PD);
  assign dac_filt_rst = (d_st == ST_PD);
  assign adc_data_out = adc_valid ? adc_data_in : '0;

  // R2
  adc_pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_on |=> (adc_state == ST_PD && adc_filt_rst));

  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_valid) |-> ($past(a_st) == ST_INIT && $past(cnt) == LAST));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_st == ST_INIT && a_on && !fr_rise) |=> $stable(cnt));

  // R3
  dac_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_on |=> (dac_state == ST_RUN && !dac_filt_rst));

  // R5
  mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_state != ST_RUN) |-> (adc_data_out == '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_st == ST_PD) |-> (cnt == '0));

endmodule

// File: tb/sim_conv_pwr_seq.sv
module sim_conv_pwr_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic adc_pd_n = 0, dac_pd_n = 0, frame_clk = 0;
  logic [15:0] adc_data_in = 0;
  logic [15:0] adc_data_out;
  logic adc_filt_rst, dac_filt_rst, adc_valid;
  logic [1:0] adc_state, dac_state;

  conv_pwr_seq u0 (.clk(clk), .rst_n(rst_n), .adc_pd_n(adc_pd_n), .dac_pd_n(dac_pd_n),
    .frame_clk(frame_clk), .adc_data_in(adc_data_in), .adc_data_out(adc_data_out),
    .adc_filt_rst(adc_filt_rst), .dac_filt_rst(dac_filt_rst), .adc_state(adc_state),
    .dac_state(dac_state), .adc_valid(adc_valid));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference: histories of samples, index i = sample i edges ago
  bit ah[0:3], dh[0:3], fh[0:3];
  int m_a = 0, m_d = 0, m_cnt = 0;
  bit fr_en = 0;
  int fr_div = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ah[i] = 0; dh[i] = 0; fh[i] = 0; end
      m_a = 0; m_d = 0; m_cnt = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin ah[i] = ah[i-1]; dh[i] = dh[i-1]; fh[i] = fh[i-1]; end
      ah[0] = adc_pd_n; dh[0] = dac_pd_n; fh[0] = frame_clk;
      // ah[2] is the pin sampled two edges before this one
      if (!ah[2]) begin m_a = 0; m_cnt = 0; end
      else if (m_a == 0) begin m_a = 1; m_cnt = 0; end
      else if (m_a == 1 && fh[2] && !fh[3]) begin
        m_cnt++;
        if (m_cnt == 2081) begin m_a = 2; m_cnt = 0; end
      end
      m_d = dh[2] ? 2 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 R4 R6 R7 R8 adc_state", adc_state, m_a);
    chk("R3 R6 dac_state", dac_state, m_d);
    chk("R4 adc_valid", adc_valid, m_a == 2);
    chk("R5 adc_data_out", adc_data_out, (m_a == 2) ? adc_data_in : 0);
    chk("R2 adc_filt_rst", adc_filt_rst, m_a == 0);
    chk("R3 dac_filt_rst", dac_filt_rst, m_d == 0);
  end

  // frame clock: period 8 clocks
  always @(posedge clk) begin
    #2;
    if (fr_en) begin
      fr_div = (fr_div + 1) % 4;
      if (fr_div == 0) frame_clk = ~frame_clk;
    end
    adc_data_in = adc_data_in * 16'd37 + 16'd4099;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    wait_clk(4);
    // R1 reset state
    chk("R1 reset adc_state", adc_state, 0);
    chk("R1 reset dac_state", dac_state, 0);
    chk("R1 reset filt", {adc_filt_rst, dac_filt_rst}, 3);
    chk("R1 reset valid/data", {adc_valid, adc_data_out}, 0);
    rst_n = 1;
    fr_en = 1;
    wait_clk(10);
    dac_pd_n = 1;                  // R3
    wait_clk(10);
    adc_pd_n = 1;                  // R4 first window
    wait_clk(8 * 1000);
    dac_pd_n = 0; wait_clk(20);    // R6 DAC toggled inside the ADC window
    dac_pd_n = 1; wait_clk(8 * 300);
    adc_pd_n = 0; wait_clk(1);     // R7 one-clock drop mid count
    adc_pd_n = 1;
    wait_clk(8 * 2081 + 40);       // full window again, then run
    chk("R4 running after full window", adc_state, 2);
    dac_pd_n = 0; wait_clk(15);    // R6 ADC keeps running
    chk("R6 adc still runs", adc_valid, 1);
    dac_pd_n = 1; wait_clk(30);
    adc_pd_n = 0; wait_clk(12);    // R2
    chk("R6 dac unaffected by adc", dac_state, 2);
    adc_pd_n = 1; wait_clk(8 * 500);
    repeat (6) begin               // R7 R8 drops phased against frame edges
      adc_pd_n = 0; wait_clk(1);
      adc_pd_n = 1; wait_clk(37);
    end
    wait_clk(8 * 2081 + 40);
    chk("R4 run after restarts", adc_state, 2);
    wait_clk(50);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    fails++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule